// File: doc/BRIEF.md
# PS/2 Device Register and Interrupt Interface

This block is the software-visible face of a device-side PS/2 controller. It holds a control word, a status word and an interrupt-flag word behind a small word-wide bus with separate read and write strobes. The transmit and receive engines sit outside the block. They report events to it as single-cycle strobes and level inputs. In return the block gives them the enable, the acknowledge policy, the transmit depth, a FIFO-clear strobe, the current byte index and the empty flag.

The block passes the raw clock and data lines through a two-flop synchronizer and reports the synchronized levels in the status word. It chooses the open-drain drive for both lines: either the engines' requests, or a level forced from the control word when software override is on. Four event flags (receive, transmit, frame error, receive overwrite) are cleared by writing 1 to them. The receive and transmit flags, each masked by its own enable, are combined into one interrupt output.

Register select is `bus_addr` as a word index: 0 is control, 1 is status, 2 is interrupt flags, and any other index reads 0 and ignores writes.

Top module: `ps2dev_regif`

## Requirements
- R1: After synchronous reset, all three registers read 0, `irq` is 0, `tx_idx` is 0, `tx_empty` is 0, and with the engine drive requests low both line drivers are released (0).
- R2: The control word holds enable at bit 0, transmit interrupt enable at bit 1, receive interrupt enable at bit 2, transmit depth minus one at bits 6:3, strict acknowledge policy at bit 7, FIFO clear at bit 8, override at bit 9, forced clock level at bit 10 and forced data level at bit 11. Writing 0xFFF reads back 0xEFF, because the clear bit always reads 0.
- R3: With override at 0, `clk_drv_low` and `dat_drv_low` follow `sm_clk_low` and `sm_dat_low`. With override at 1, they equal the inverse of the forced clock and data bits, whatever the engines request.
- R4: Interrupt flag bit 0 (receive, set by `rx_done`), bit 1 (transmit, set by `tx_stop_done`), status bit 2 (frame error, set by `rx_frame_err`) and status bit 6 (overwrite) are cleared by writing 1 and are unchanged by writing 0. If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R5: `irq` is 1 exactly when (receive flag AND receive enable) OR (transmit flag AND transmit enable).
- R6: Writing control bit 8 as 1 sets `tx_empty` to 1, resets `tx_idx` to 0 at the same clock edge, and raises `tx_fifo_clr` for exactly one cycle on the next edge.
- R7: The status word reports the synchronized clock at bit 0, data at bit 1, frame error at bit 2, last received parity at bit 3, receive busy at bit 4, transmit busy at bit 5, overwrite at bit 6, transmit-empty at bit 7 and byte index at bits 11:8. A write of all ones to the status word changes none of bits 0, 1, 3, 4, 5, 7 or 11:8.
- R8: While `tx_empty` is 0, each `tx_byte_sent` pulse increments `tx_idx`. The pulse that arrives when `tx_idx` equals the programmed depth field (that is, after depth+1 bytes) sets `tx_empty` and returns `tx_idx` to 0. Pulses are ignored while `tx_empty` is 1.
- R9: `rx_done` captures `rx_par` as the reported parity. An `rx_done` arriving while the receive flag is still set also sets the overwrite flag.
- R10: A change on `ps2_clk_in` or `ps2_dat_in` is visible on `clk_sync` / `dat_sync` after two clock edges. A status read issued on the first cycle after the change still shows the old level; one issued a cycle later shows the new level.
- R11: `tx_fill` clears `tx_empty` only while enable is 1. Otherwise it has no effect.
- R12: `bus_rdata` takes the selected register's value on the edge at which `bus_rd` is sampled high, and holds its value while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| ps2_clk_in | input | 1 | Raw clock line level |
| ps2_dat_in | input | 1 | Raw data line level |
| sm_clk_low | input | 1 | Engine request to pull clock low |
| sm_dat_low | input | 1 | Engine request to pull data low |
| clk_drv_low | output | 1 | Open-drain pull-down enable for clock |
| dat_drv_low | output | 1 | Open-drain pull-down enable for data |
| rx_done | input | 1 | Strobe: a byte was received and acknowledged |
| rx_par | input | 1 | Parity bit of the byte flagged by rx_done |
| rx_frame_err | input | 1 | Strobe: stop bit missing |
| rx_busy | input | 1 | Receiver active |
| tx_busy | input | 1 | Transmitter active |
| tx_fill | input | 1 | Strobe: software placed data in the transmit buffer |
| tx_byte_sent | input | 1 | Strobe: one byte left the transmit buffer |
| tx_stop_done | input | 1 | Strobe: stop bit transmitted |
| ctl_enable | output | 1 | Controller enable |
| ctl_ack_strict | output | 1 | Withhold acknowledge on parity or stop error |
| ctl_depth | output | 4 | Transmit depth minus one |
| tx_fifo_clr | output | 1 | One-cycle transmit abort strobe |
| tx_idx | output | 4 | Current transmit byte index |
| tx_empty | output | 1 | Transmit buffer empty |
| clk_sync | output | 1 | Synchronized clock line |
| dat_sync | output | 1 | Synchronized data line |
| irq | output | 1 | Combined masked interrupt |

## Verification
The case that is hardest to reach from the ports is a clearing write and a set event landing on the same clock edge. The bench places both strobes in the same negative-edge slot, so that one rising edge sees them together, and then reads the flag back. The transmit index is the other hard case, because the terminal count depends on the programmed depth. The bench therefore sweeps all sixteen depths, checking the index after every byte pulse, the moment the buffer reports empty, and that further pulses are ignored. The override path and the interrupt gating are swept over all combinations of their inputs.

// File: rtl/ps2_regif_pkg.sv
// Package: field positions, register select codes and the control record
// shared by the PS/2 device register interface.
package ps2_regif_pkg;
    localparam int TX_IDX_W = 4;

    // control word fields
    localparam int CTL_EN    = 0;
    localparam int CTL_TXIE  = 1;
    localparam int CTL_RXIE  = 2;
    localparam int CTL_DEP_L = 3;
    localparam int CTL_ACK   = 7;
    localparam int CTL_CLR   = 8;
    localparam int CTL_OVR   = 9;
    localparam int CTL_FCLK  = 10;
    localparam int CTL_FDAT  = 11;

    // status word fields
    localparam int ST_CLK    = 0;
    localparam int ST_DAT    = 1;
    localparam int ST_FERR   = 2;
    localparam int ST_PAR    = 3;
    localparam int ST_RXB    = 4;
    localparam int ST_TXB    = 5;
    localparam int ST_OV     = 6;
    localparam int ST_EMPTY  = 7;
    localparam int ST_IDX_L  = 8;

    // interrupt flag word fields
    localparam int IF_RX     = 0;
    localparam int IF_TX     = 1;

    // order of flags inside the write-1-to-clear bank
    localparam int FL_RX     = 0;
    localparam int FL_TX     = 1;
    localparam int FL_FERR   = 2;
    localparam int FL_OV     = 3;
    localparam int FL_NUM    = 4;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_IFLAG = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic                fdat;
        logic                fclk;
        logic                ovr;
        logic                ack;
        logic [TX_IDX_W-1:0] depth;
        logic                rxie;
        logic                txie;
        logic                en;
    } ctrl_t;
endpackage

// File: rtl/ps2_sync.sv
// Module: multi-stage synchronizer for asynchronous line levels.
// Assumes: each bit is independent; STAGES >= 2; reset value 0.
module ps2_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_q;

    // shift the raw levels through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ps2_w1c_flag.sv
// Module: bank of sticky event flags, set by hardware strobes and cleared
// by a software write of 1. Assumes: set has priority over clear.
module ps2_w1c_flag #(
    parameter int NUM = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] set_i,
    input  logic [NUM-1:0] clr_i,
    output logic [NUM-1:0] flag_o
);
    for (genvar gi = 0; gi < NUM; gi++) begin : g_flag
        logic flag_q;

        // hold the flag until a clearing write without a coincident event
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q <= 1'b0;
            else if (set_i[gi])  flag_q <= 1'b1;
            else if (clr_i[gi])  flag_q <= 1'b0;
        end

        assign flag_o[gi] = flag_q;

        p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[gi] |=> flag_o[gi]);
        p_w1c_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[gi] && !set_i[gi]) |=> !flag_o[gi]);
        p_w1c_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[gi] && !set_i[gi]) |=> $stable(flag_o[gi]));
    end
endmodule

// File: rtl/ps2_tx_index.sv
// Module: transmit byte index and empty tracker. Counts bytes leaving the
// buffer against the programmed depth; clear aborts without touching data.
// Assumes: depth field holds (bytes - 1); clear has top priority.
module ps2_tx_index #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic [IDX_W-1:0] depth_i,
    input  logic             fill_i,
    input  logic             sent_i,
    input  logic             clr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             empty_o
);
    logic [IDX_W-1:0] idx_q;
    logic             empty_q;
    logic             last_byte;

    assign last_byte = (idx_q == depth_i);

    // advance the index, detect the terminal byte, honour abort and refill
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q   <= '0;
            empty_q <= 1'b0;
        end else if (clr_i) begin
            idx_q   <= '0;
            empty_q <= 1'b1;
        end else begin
            if (sent_i && !empty_q) begin
                if (last_byte) begin
                    idx_q   <= '0;
                    empty_q <= 1'b1;
                end else begin
                    idx_q   <= idx_q + 1'b1;
                end
            end
            if (fill_i && enable_i) empty_q <= 1'b0;
        end
    end

    assign idx_o   = idx_q;
    assign empty_o = empty_q;

    p_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (empty_o && idx_o == '0));
    p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!fill_i && !sent_i && !clr_i) |=> ($stable(empty_o) && $stable(idx_o)));
    p_terminal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_i && !clr_i && !fill_i && !empty_o && idx_o == depth_i) |=> (empty_o && idx_o == '0));
    p_fill_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_i && !enable_i && !clr_i && !sent_i) |=> $stable(empty_o));
endmodule

// File: rtl/ps2_line_mux.sv
// Module: selects the open-drain pull-down requests for the clock and
// data lines. Assumes: a driver value of 1 pulls the line low.
module ps2_line_mux (
    input  logic ovr_i,
    input  logic force_clk_i,
    input  logic force_dat_i,
    input  logic sm_clk_low_i,
    input  logic sm_dat_low_i,
    output logic clk_low_o,
    output logic dat_low_o
);
    // software-forced level wins over the engines while override is on
    always_comb begin
        if (ovr_i) begin
            clk_low_o = ~force_clk_i;
            dat_low_o = ~force_dat_i;
        end else begin
            clk_low_o = sm_clk_low_i;
            dat_low_o = sm_dat_low_i;
        end
    end
endmodule

// File: rtl/ps2dev_regif.sv
// Module: register and interrupt interface of a device-side PS/2
// controller. Holds control, status and interrupt-flag words, combines
// masked flags into one interrupt and arbitrates the line drivers.
// Assumes: single-cycle bus strobes, word-index addressing, registered
// read data one cycle after bus_rd.
module ps2dev_regif
    import ps2_regif_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                ps2_clk_in,
    input  logic                ps2_dat_in,
    input  logic                sm_clk_low,
    input  logic                sm_dat_low,
    output logic                clk_drv_low,
    output logic                dat_drv_low,
    input  logic                rx_done,
    input  logic                rx_par,
    input  logic                rx_frame_err,
    input  logic                rx_busy,
    input  logic                tx_busy,
    input  logic                tx_fill,
    input  logic                tx_byte_sent,
    input  logic                tx_stop_done,
    output logic                ctl_enable,
    output logic                ctl_ack_strict,
    output logic [TX_IDX_W-1:0] ctl_depth,
    output logic                tx_fifo_clr,
    output logic [TX_IDX_W-1:0] tx_idx,
    output logic                tx_empty,
    output logic                clk_sync,
    output logic                dat_sync,
    output logic                irq
);
    localparam int SYNC_STAGES = 2;
    localparam int SEL_W       = 2;

    ctrl_t             ctrl_q;
    reg_sel_e          sel;
    logic              addr_ok;
    logic              wr_ctrl, wr_stat, wr_iflag;
    logic              clr_now;
    logic              fifo_clr_q;
    logic              par_q;
    logic [FL_NUM-1:0] fl_set, fl_clr, fl;
    logic [1:0]        lines_sync;
    logic [DATA_W-1:0] ctrl_word, stat_word, iflag_word, rd_mux;
    logic [DATA_W-1:0] rdata_q;

    // decode the word index into a register select
    always_comb begin
        addr_ok = ((bus_addr >> SEL_W) == '0);
        sel     = addr_ok ? reg_sel_e'(bus_addr[SEL_W-1:0]) : SEL_NONE;
    end

    assign wr_ctrl  = bus_wr && (sel == SEL_CTRL);
    assign wr_stat  = bus_wr && (sel == SEL_STAT);
    assign wr_iflag = bus_wr && (sel == SEL_IFLAG);
    assign clr_now  = wr_ctrl && bus_wdata[CTL_CLR];

    // load the control fields; the clear bit is not stored
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.en    <= bus_wdata[CTL_EN];
            ctrl_q.txie  <= bus_wdata[CTL_TXIE];
            ctrl_q.rxie  <= bus_wdata[CTL_RXIE];
            ctrl_q.depth <= bus_wdata[CTL_DEP_L +: TX_IDX_W];
            ctrl_q.ack   <= bus_wdata[CTL_ACK];
            ctrl_q.ovr   <= bus_wdata[CTL_OVR];
            ctrl_q.fclk  <= bus_wdata[CTL_FCLK];
            ctrl_q.fdat  <= bus_wdata[CTL_FDAT];
        end
    end

    // produce the one-cycle abort strobe for the transmitter
    always_ff @(posedge clk) begin
        if (!rst_n) fifo_clr_q <= 1'b0;
        else        fifo_clr_q <= clr_now;
    end

    // capture the parity of each received byte
    always_ff @(posedge clk) begin
        if (!rst_n)       par_q <= 1'b0;
        else if (rx_done) par_q <= rx_par;
    end

    // route engine events and software clears into the flag bank
    always_comb begin
        fl_set          = '0;
        fl_set[FL_RX]   = rx_done;
        fl_set[FL_TX]   = tx_stop_done;
        fl_set[FL_FERR] = rx_frame_err;
        fl_set[FL_OV]   = rx_done && fl[FL_RX];
        fl_clr          = '0;
        fl_clr[FL_RX]   = wr_iflag && bus_wdata[IF_RX];
        fl_clr[FL_TX]   = wr_iflag && bus_wdata[IF_TX];
        fl_clr[FL_FERR] = wr_stat  && bus_wdata[ST_FERR];
        fl_clr[FL_OV]   = wr_stat  && bus_wdata[ST_OV];
    end

    ps2_w1c_flag #(.NUM(FL_NUM)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fl_set),
        .clr_i  (fl_clr),
        .flag_o (fl)
    );

    ps2_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ps2_dat_in, ps2_clk_in}),
        .sync_o  (lines_sync)
    );

    ps2_tx_index #(.IDX_W(TX_IDX_W)) u_txidx (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (ctrl_q.en),
        .depth_i  (ctrl_q.depth),
        .fill_i   (tx_fill),
        .sent_i   (tx_byte_sent),
        .clr_i    (clr_now),
        .idx_o    (tx_idx),
        .empty_o  (tx_empty)
    );

    ps2_line_mux u_lines (
        .ovr_i        (ctrl_q.ovr),
        .force_clk_i  (ctrl_q.fclk),
        .force_dat_i  (ctrl_q.fdat),
        .sm_clk_low_i (sm_clk_low),
        .sm_dat_low_i (sm_dat_low),
        .clk_low_o    (clk_drv_low),
        .dat_low_o    (dat_drv_low)
    );

    // assemble the three readable words
    always_comb begin
        ctrl_word                        = '0;
        ctrl_word[CTL_EN]                = ctrl_q.en;
        ctrl_word[CTL_TXIE]              = ctrl_q.txie;
        ctrl_word[CTL_RXIE]              = ctrl_q.rxie;
        ctrl_word[CTL_DEP_L +: TX_IDX_W] = ctrl_q.depth;
        ctrl_word[CTL_ACK]               = ctrl_q.ack;
        ctrl_word[CTL_OVR]               = ctrl_q.ovr;
        ctrl_word[CTL_FCLK]              = ctrl_q.fclk;
        ctrl_word[CTL_FDAT]              = ctrl_q.fdat;

        stat_word                        = '0;
        stat_word[ST_CLK]                = lines_sync[0];
        stat_word[ST_DAT]                = lines_sync[1];
        stat_word[ST_FERR]               = fl[FL_FERR];
        stat_word[ST_PAR]                = par_q;
        stat_word[ST_RXB]                = rx_busy;
        stat_word[ST_TXB]                = tx_busy;
        stat_word[ST_OV]                 = fl[FL_OV];
        stat_word[ST_EMPTY]              = tx_empty;
        stat_word[ST_IDX_L +: TX_IDX_W]  = tx_idx;

        iflag_word                       = '0;
        iflag_word[IF_RX]                = fl[FL_RX];
        iflag_word[IF_TX]                = fl[FL_TX];
    end

    // pick the selected word for the read port
    always_comb begin
        case (sel)
            SEL_CTRL:  rd_mux = ctrl_word;
            SEL_STAT:  rd_mux = stat_word;
            SEL_IFLAG: rd_mux = iflag_word;
            default:   rd_mux = '0;
        endcase
    end

    // register read data on each read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata      = rdata_q;
    assign tx_fifo_clr    = fifo_clr_q;
    assign ctl_enable     = ctrl_q.en;
    assign ctl_ack_strict = ctrl_q.ack;
    assign ctl_depth      = ctrl_q.depth;
    assign clk_sync       = lines_sync[0];
    assign dat_sync       = lines_sync[1];
    assign irq            = (fl[FL_RX] && ctrl_q.rxie) || (fl[FL_TX] && ctrl_q.txie);

    p_clr_reads0_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_W'(0)) |=> !bus_rdata[CTL_CLR]);
    p_ovr_force_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[CTL_OVR]) |=> (clk_drv_low == !$past(bus_wdata[CTL_FCLK])
                                          && dat_drv_low == !$past(bus_wdata[CTL_FDAT])));
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(rx_done) || $past(tx_stop_done) || $past(wr_ctrl)));
    p_clr_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_now |=> tx_fifo_clr);
    p_ov_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && iflag_word[IF_RX]) |=> stat_word[ST_OV]);
    p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/ps2dev_regif_bench.sv
module ps2dev_regif_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [1:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        ps2_clk_in = 0, ps2_dat_in = 0, sm_clk_low = 0, sm_dat_low = 0;
    logic        clk_drv_low, dat_drv_low;
    logic        rx_done = 0, rx_par = 0, rx_frame_err = 0, rx_busy = 0, tx_busy = 0;
    logic        tx_fill = 0, tx_byte_sent = 0, tx_stop_done = 0;
    logic        ctl_enable, ctl_ack_strict, tx_fifo_clr, tx_empty, clk_sync, dat_sync, irq;
    logic [3:0]  ctl_depth, tx_idx;
    int          checks = 0, errors = 0;
    bit          done = 0;
    logic [31:0] rv;

    always #2 clk = ~clk;

    ps2dev_regif u_ps2dev_regif (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ps2_clk_in(ps2_clk_in),
        .ps2_dat_in(ps2_dat_in), .sm_clk_low(sm_clk_low), .sm_dat_low(sm_dat_low),
        .clk_drv_low(clk_drv_low), .dat_drv_low(dat_drv_low), .rx_done(rx_done),
        .rx_par(rx_par), .rx_frame_err(rx_frame_err), .rx_busy(rx_busy), .tx_busy(tx_busy),
        .tx_fill(tx_fill), .tx_byte_sent(tx_byte_sent), .tx_stop_done(tx_stop_done),
        .ctl_enable(ctl_enable), .ctl_ack_strict(ctl_ack_strict), .ctl_depth(ctl_depth),
        .tx_fifo_clr(tx_fifo_clr), .tx_idx(tx_idx), .tx_empty(tx_empty),
        .clk_sync(clk_sync), .dat_sync(dat_sync), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a;
        @(negedge clk); bus_rd = 0; d = bus_rdata;
    endtask

    // 0 rx_done, 1 tx_stop_done, 2 rx_frame_err, 3 tx_fill, 4 tx_byte_sent
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rx_done = 1;
            1: tx_stop_done = 1;
            2: rx_frame_err = 1;
            3: tx_fill = 1;
            default: tx_byte_sent = 1;
        endcase
        @(negedge clk);
        rx_done = 0; tx_stop_done = 0; rx_frame_err = 0; tx_fill = 0; tx_byte_sent = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(2'd0, rv); chk("R1 ctrl", rv, 0);
        rd(2'd1, rv); chk("R1 status", rv, 0);
        rd(2'd2, rv); chk("R1 iflag", rv, 0);
        chk("R1 irq/idx/empty/drv", {irq, tx_idx, tx_empty, clk_drv_low, dat_drv_low}, 0);

        // R2 control layout and self-clearing clear bit
        wr(2'd0, 32'hFFF); rd(2'd0, rv); chk("R2 readback", rv, 32'hEFF);
        chk("R2 fields", {ctl_enable, ctl_ack_strict, ctl_depth}, {1'b1, 1'b1, 4'hF});
        wr(2'd0, 32'h0A5); rd(2'd0, rv); chk("R2 pattern", rv, 32'h0A5);

        // R3 override sweep over forced levels and engine requests
        for (int m = 0; m < 32; m++) begin
            logic ov, fc, fd, sc, sd;
            {ov, fc, fd, sc, sd} = m[4:0];
            wr(2'd0, {20'd0, fd, fc, ov, 9'd0});
            sm_clk_low = sc; sm_dat_low = sd;
            @(negedge clk);
            chk("R3 line drive", {clk_drv_low, dat_drv_low},
                ov ? {!fc, !fd} : {sc, sd});
        end
        sm_clk_low = 0; sm_dat_low = 0;
        wr(2'd0, 0);

        // R5 interrupt gating sweep
        for (int m = 0; m < 16; m++) begin
            logic ri, ti, rf, tf;
            {ri, ti, rf, tf} = m[3:0];
            wr(2'd2, 32'h3); wr(2'd1, 32'h44);
            wr(2'd0, {29'd0, ri, ti, 1'b1});
            if (rf) pulse(0);
            if (tf) pulse(1);
            @(negedge clk);
            chk("R5 irq", irq, (rf & ri) | (tf & ti));
        end

        // R4 write-0 keeps, write-1 clears, set wins
        wr(2'd2, 32'h3); wr(2'd1, 32'h44); wr(2'd0, 32'h7);
        pulse(0); pulse(1); pulse(2);
        wr(2'd2, 32'h0); wr(2'd1, 32'h0);
        rd(2'd2, rv); chk("R4 write0 iflag", rv, 32'h3);
        rd(2'd1, rv); chk("R4 write0 ferr", rv[2], 1);
        wr(2'd2, 32'h1); rd(2'd2, rv); chk("R4 clear rx only", rv, 32'h2);
        wr(2'd1, 32'h4); rd(2'd1, rv); chk("R4 clear ferr", rv[2], 0);
        @(negedge clk); bus_wr = 1; bus_addr = 2'd2; bus_wdata = 32'h2; tx_stop_done = 1;
        @(negedge clk); bus_wr = 0; bus_wdata = 0; tx_stop_done = 0;
        rd(2'd2, rv); chk("R4 set wins", rv[1], 1);
        wr(2'd2, 32'h3); rd(2'd2, rv); chk("R4 clear both", rv, 0);

        // R9 parity capture and overwrite
        wr(2'd1, 32'h44);
        rx_par = 1; pulse(0); rx_par = 0;
        rd(2'd1, rv); chk("R9 parity no ov", {rv[6], rv[3]}, 2'b01);
        pulse(0);
        rd(2'd1, rv); chk("R9 overwrite", {rv[6], rv[3]}, 2'b10);
        wr(2'd1, 32'h40); rd(2'd1, rv); chk("R4 clear ov", rv[6], 0);
        wr(2'd2, 32'h3);

        // R6 clear strobe, index and empty
        wr(2'd0, 32'h1 | (32'd7 << 3));
        pulse(3); pulse(4); pulse(4); pulse(4);
        chk("R8 idx before clear", {tx_empty, tx_idx}, {1'b0, 4'd3});
        @(negedge clk); bus_wr = 1; bus_addr = 2'd0; bus_wdata = 32'h1 | (32'd7 << 3) | 32'h100;
        @(negedge clk); bus_wr = 0; bus_wdata = 0;
        chk("R6 clear", {tx_fifo_clr, tx_empty, tx_idx}, {1'b1, 1'b1, 4'd0});
        @(negedge clk); chk("R6 single cycle", tx_fifo_clr, 0);

        // R11 fill ignored while disabled
        wr(2'd0, 32'h0); pulse(3); chk("R11 fill disabled", tx_empty, 1);
        wr(2'd0, 32'h1); pulse(3); chk("R11 fill enabled", tx_empty, 0);

        // R8 sweep of every depth
        for (int d = 0; d < 16; d++) begin
            wr(2'd0, 32'h101 | (d << 3));
            pulse(3);
            for (int k = 1; k <= d; k++) begin
                pulse(4);
                chk("R8 idx step", {tx_empty, tx_idx}, {1'b0, 4'(k)});
            end
            pulse(4);
            chk("R8 terminal", {tx_empty, tx_idx}, {1'b1, 4'd0});
            pulse(4);
            chk("R8 ignore when empty", {tx_empty, tx_idx}, {1'b1, 4'd0});
        end

        // R7 layout and read-only bits
        wr(2'd0, 32'h1 | (32'd5 << 3)); pulse(3); pulse(4); pulse(4);
        rx_busy = 1; tx_busy = 0; rx_par = 1; pulse(0); rx_par = 0;
        wr(2'd2, 32'h3);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, rv);
        chk("R7 status ro", rv, {20'd0, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0});
        rx_busy = 0; tx_busy = 1;
        @(negedge clk); rd(2'd1, rv); chk("R7 tx busy", rv[5:4], 2'b10);
        tx_busy = 0;

        // R10 synchronizer latency
        @(negedge clk); ps2_clk_in = 1; ps2_dat_in = 1;
        rd(2'd1, rv); chk("R10 early read", rv[1:0], 2'b00);
        rd(2'd1, rv); chk("R10 late read", rv[1:0], 2'b11);
        chk("R10 sync ports", {clk_sync, dat_sync}, 2'b11);

        // R12 read data held without a read strobe
        wr(2'd0, 32'h3); rd(2'd0, rv);
        wr(2'd0, 32'h5);
        repeat (2) @(negedge clk);
        chk("R12 hold", bus_rdata, 32'h3);
        rd(2'd3, rv); chk("R12 unused index", rv, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule